// File: doc/BRIEF.md
# Debug Register Access Trap Checker

This block decides, in the same cycle as the request, whether a software access to one of a small set of debug system registers may proceed or must be redirected to a higher privilege level. Every register belongs to one of four classes: power-down, debug ROM, general debug, or comms channel. The decision uses the current privilege level (0 to 3), the level-2 and level-3 trap configuration bits, the hypervisor general-trap bit, a fine-grained-trap feature flag and the level-1 comms trap bit. The result is reported on a 2-bit response.

The block also holds the registers behind that decision. These are an OS lock, which is set through a lock-access register with either a 32-bit key write or a 64-bit bit-0 write, a read-only lock status, an optional double-lock bit, and 8 claim tags with separate set and clear views. The bus is a plain valid/write/address/data request. Read data and the response are combinational. A write takes effect at the next rising clock edge, and only when the response is "allowed".

The OS lock is a two-state machine with states LK_OPEN and LK_HELD. Reset enters LK_HELD. Transition LOCK_SET (LK_OPEN to LK_HELD) fires on an allowed lock-access write that asks for the lock. Transition LOCK_CLEAR (LK_HELD to LK_OPEN) fires on an allowed lock-access write that does not ask for it. Every other cycle holds the state.

Top module: `dbgtrap_top`

## Requirements
- R1: The response is 0 when the access is allowed, 1 for a trap to level 1, 2 for level 2 and 3 for level 3. A comms-channel access from level 0 with the level-1 comms trap bit set responds 1, whatever the level-2 and level-3 bits say.
- R2: For the power-down, ROM and general classes, a level-2 trap (2) is taken when the level is 0 or 1 and any one of these bits is set: the class's own level-2 bit (power-down uses l2_pdown, ROM uses l2_rom, general uses l2_dbg), l2_tde, or hyp_tge.
- R3: The level-3 trap (3) applies only when the level is below 3 and no level-2 trap was taken. The power-down class uses l3_pdown, and the ROM and general classes use l3_dbg.
- R4: Comms-channel accesses trap to level 2 on l2_dbg, l2_tde or hyp_tge, and to level 3 on l3_dbg. The dedicated bits l2_comms and l3_comms count only when fgt_present is 1.
- R5: A trapped access returns zero read data and changes no register state.
- R6: Address map: 0 lock access, 1 lock status, 2 double lock, 3 claim set, 4 claim clear, 5 ROM (reads 0), 6 comms (reads 0), 7 general (reads 0). Classes: 0, 1 and 2 are power-down; 5 is ROM; 6 is comms; 3, 4 and 7 are general.
- R7: In the 32-bit form (req_wide=0), a lock-access write holds the lock only when the data equals 0xC5ACCE55. Any other value releases it.
- R8: In the 64-bit form (req_wide=1), a lock-access write holds the lock exactly when data bit 0 is 1.
- R9: Lock status reads 8 plus 2 times the lock state. After reset it reads 10 (locked).
- R10: A claim-set write ORs data bits 7:0 into the tags, and a claim-set read returns 0xFF. A claim-clear write clears the tags whose data bit is 1, and a claim-clear read returns the tags. The tags reset to 0.
- R11: With DLOCK_EN=1, the double-lock register stores data bit 0 and reads it back. With DLOCK_EN=0, it reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Register address |
| req_wdata | input | 32 | Write data |
| req_wide | input | 1 | 1 = 64-bit access form, 0 = 32-bit form |
| cur_el | input | 2 | Current privilege level |
| l1_comms | input | 1 | Level-1 comms trap bit |
| l2_pdown | input | 1 | Level-2 power-down trap bit |
| l2_rom | input | 1 | Level-2 ROM trap bit |
| l2_dbg | input | 1 | Level-2 general debug trap bit |
| l2_tde | input | 1 | Level-2 trap-debug-exceptions bit |
| l2_comms | input | 1 | Level-2 comms trap bit (needs fgt_present) |
| hyp_tge | input | 1 | Hypervisor general-trap bit |
| l3_pdown | input | 1 | Level-3 power-down trap bit |
| l3_dbg | input | 1 | Level-3 general debug access trap bit |
| l3_comms | input | 1 | Level-3 comms trap bit (needs fgt_present) |
| fgt_present | input | 1 | Fine-grained-trap feature flag |
| rdata | output | 32 | Read data, 0 when trapped or writing |
| resp | output | 2 | Trap response code |

## Verification
The case that matters is a trap decision and a register update landing in the same cycle. A write to the lock, claim or double-lock register can arrive while trap bits are set for the current level, and the trap must suppress the write. The bench issues such writes with level-2 and level-3 bits raised and checks that the response is non-zero and the read data is zero. It then clears the bits and reads the registers back, expecting the values from before the trapped write. The classification itself is swept with a vector table of levels, classes and bit combinations.

// File: rtl/dbgtrap_pkg.sv
package dbgtrap_pkg;

    localparam int REG_ADDR_W = 3;

    typedef enum logic [1:0] {
        RC_PDOWN = 2'd0,
        RC_ROM   = 2'd1,
        RC_GEN   = 2'd2,
        RC_COMMS = 2'd3
    } reg_class_e;

    typedef enum logic [1:0] {
        RSP_OK = 2'd0,
        RSP_L1 = 2'd1,
        RSP_L2 = 2'd2,
        RSP_L3 = 2'd3
    } trap_rsp_e;

    typedef struct packed {
        logic fgt;
        logic l1_comms;
        logic tge;
        logic l2_tde;
        logic l2_pdown;
        logic l2_rom;
        logic l2_dbg;
        logic l2_comms;
        logic l3_pdown;
        logic l3_dbg;
        logic l3_comms;
    } trap_cfg_t;

    localparam logic [REG_ADDR_W-1:0] A_LOCK  = 3'd0;
    localparam logic [REG_ADDR_W-1:0] A_STAT  = 3'd1;
    localparam logic [REG_ADDR_W-1:0] A_DLK   = 3'd2;
    localparam logic [REG_ADDR_W-1:0] A_CSET  = 3'd3;
    localparam logic [REG_ADDR_W-1:0] A_CCLR  = 3'd4;
    localparam logic [REG_ADDR_W-1:0] A_ROM   = 3'd5;
    localparam logic [REG_ADDR_W-1:0] A_COMMS = 3'd6;

    function automatic reg_class_e class_of(input logic [REG_ADDR_W-1:0] a);
        reg_class_e c;
        unique case (a)
            A_LOCK, A_STAT, A_DLK: c = RC_PDOWN;
            A_ROM:                 c = RC_ROM;
            A_COMMS:               c = RC_COMMS;
            default:               c = RC_GEN;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/dbgtrap_classify.sv
module dbgtrap_classify
    import dbgtrap_pkg::*;
(
    input  logic [1:0]  cur_el,
    input  reg_class_e  cls,
    input  trap_cfg_t   cfg,
    output trap_rsp_e   rsp
);
    logic below2;
    logic below3;
    logic l2_hit;
    logic l3_hit;
    logic l2_common;
    logic l1_hit;

    assign below2    = (cur_el < 2'd2);
    assign below3    = (cur_el != 2'd3);
    assign l2_common = cfg.l2_tde | cfg.tge;
    assign l1_hit    = (cls == RC_COMMS) && (cur_el == 2'd0) && cfg.l1_comms;

    always_comb begin
        l2_hit = 1'b0;
        l3_hit = 1'b0;
        unique case (cls)
            RC_PDOWN: begin
                l2_hit = cfg.l2_pdown | l2_common;
                l3_hit = cfg.l3_pdown;
            end
            RC_ROM: begin
                l2_hit = cfg.l2_rom | l2_common;
                l3_hit = cfg.l3_dbg;
            end
            RC_GEN: begin
                l2_hit = cfg.l2_dbg | l2_common;
                l3_hit = cfg.l3_dbg;
            end
            RC_COMMS: begin
                l2_hit = cfg.l2_dbg | l2_common | (cfg.fgt & cfg.l2_comms);
                l3_hit = cfg.l3_dbg | (cfg.fgt & cfg.l3_comms);
            end
            default: begin
                l2_hit = 1'b0;
                l3_hit = 1'b0;
            end
        endcase
    end

    always_comb begin
        if (l1_hit)                rsp = RSP_L1;
        else if (below2 && l2_hit) rsp = RSP_L2;
        else if (below3 && l3_hit) rsp = RSP_L3;
        else                       rsp = RSP_OK;
    end

endmodule

// File: rtl/dbgtrap_regs.sv
module dbgtrap_regs
    import dbgtrap_pkg::*;
#(
    parameter int                DATA_W   = 32,
    parameter int                CLAIM_W  = 8,
    parameter bit                DLOCK_EN = 1'b1,
    parameter logic [DATA_W-1:0] LOCK_KEY = 32'hC5ACCE55
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic                  wide_form,
    output logic [DATA_W-1:0]     rd_value,
    output logic                  lock_q,
    output logic [CLAIM_W-1:0]    claim_q
);
    localparam logic [DATA_W-1:0] STAT_BASE = DATA_W'(8);

    typedef enum logic {LK_OPEN = 1'b0, LK_HELD = 1'b1} lock_st_e;

    lock_st_e lk_state;
    lock_st_e lk_next;
    logic     lock_wr;
    logic     lock_req;
    logic     dlk_q;

    assign lock_wr  = wr_en && (addr == A_LOCK);
    assign lock_req = wide_form ? wdata[0] : (wdata == LOCK_KEY);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lk_state <= LK_HELD;
        else        lk_state <= lk_next;
    end

    always_comb begin
        lk_next = lk_state;
        unique case (lk_state)
            LK_OPEN: if (lock_wr && lock_req)  lk_next = LK_HELD;
            LK_HELD: if (lock_wr && !lock_req) lk_next = LK_OPEN;
            default: lk_next = LK_HELD;
        endcase
    end

    assign lock_q = (lk_state == LK_HELD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            claim_q <= '0;
        end else if (wr_en && addr == A_CSET) begin
            claim_q <= claim_q | wdata[CLAIM_W-1:0];
        end else if (wr_en && addr == A_CCLR) begin
            claim_q <= claim_q & ~wdata[CLAIM_W-1:0];
        end
    end

    generate
        if (DLOCK_EN) begin : g_dlk
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                    dlk_q <= 1'b0;
                else if (wr_en && addr == A_DLK) dlk_q <= wdata[0];
            end
        end else begin : g_no_dlk
            assign dlk_q = 1'b0;
        end
    endgenerate

    always_comb begin
        rd_value = '0;
        unique case (addr)
            A_STAT:  rd_value = STAT_BASE | (DATA_W'(lock_q) << 1);
            A_DLK:   rd_value = DATA_W'(dlk_q);
            A_CSET:  rd_value = DATA_W'({CLAIM_W{1'b1}});
            A_CCLR:  rd_value = DATA_W'(claim_q);
            default: rd_value = '0;
        endcase
    end

    // R10: an unselected cycle keeps the tags
    AST_CLAIM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(claim_q)); // R10

endmodule

// File: rtl/dbgtrap_top.sv
module dbgtrap_top
    import dbgtrap_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int CLAIM_W  = 8,
    parameter bit DLOCK_EN = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [REG_ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic                  req_wide,
    input  logic [1:0]            cur_el,
    input  logic                  l1_comms,
    input  logic                  l2_pdown,
    input  logic                  l2_rom,
    input  logic                  l2_dbg,
    input  logic                  l2_tde,
    input  logic                  l2_comms,
    input  logic                  hyp_tge,
    input  logic                  l3_pdown,
    input  logic                  l3_dbg,
    input  logic                  l3_comms,
    input  logic                  fgt_present,
    output logic [DATA_W-1:0]     rdata,
    output logic [1:0]            resp
);
    trap_cfg_t          cfg;
    reg_class_e         cls;
    trap_rsp_e          rsp_e;
    logic               allowed;
    logic               wr_en;
    logic [DATA_W-1:0]  rd_value;
    logic               lock_q;
    logic [CLAIM_W-1:0] claim_q;

    assign cfg = '{fgt: fgt_present, l1_comms: l1_comms, tge: hyp_tge,
                   l2_tde: l2_tde, l2_pdown: l2_pdown, l2_rom: l2_rom,
                   l2_dbg: l2_dbg, l2_comms: l2_comms, l3_pdown: l3_pdown,
                   l3_dbg: l3_dbg, l3_comms: l3_comms};
    assign cls = class_of(req_addr);

    dbgtrap_classify u_cls (
        .cur_el (cur_el),
        .cls    (cls),
        .cfg    (cfg),
        .rsp    (rsp_e)
    );

    assign allowed = (rsp_e == RSP_OK);
    assign wr_en   = req_valid && req_write && allowed;

    dbgtrap_regs #(
        .DATA_W   (DATA_W),
        .CLAIM_W  (CLAIM_W),
        .DLOCK_EN (DLOCK_EN)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (req_addr),
        .wdata     (req_wdata),
        .wide_form (req_wide),
        .rd_value  (rd_value),
        .lock_q    (lock_q),
        .claim_q   (claim_q)
    );

    always_comb begin
        resp  = rsp_e;
        rdata = (req_valid && !req_write && allowed) ? rd_value : '0;
    end

    AST_TOP_EL_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_el == 2'd3) |-> (resp == 2'd0)); // R3
    AST_L2_ONLY_BELOW2: assert property (@(posedge clk) disable iff (!rst_n)
        (resp == 2'd2) |-> (cur_el < 2'd2)); // R2
    AST_L1_ONLY_COMMS: assert property (@(posedge clk) disable iff (!rst_n)
        (resp == 2'd1) |-> (req_addr == A_COMMS && cur_el == 2'd0)); // R1
    AST_TRAP_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (resp != 2'd0) |-> (rdata == '0)); // R5
    AST_TRAP_KEEPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && resp != 2'd0) |=> $stable(lock_q)); // R5
    AST_TRAP_KEEPS_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && resp != 2'd0) |=> $stable(claim_q)); // R5

endmodule

// File: tb/sim_dbgtrap_top.sv
`timescale 1ns/100ps
module sim_dbgtrap_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [2:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_wide = 1'b0;
    logic [1:0]  cur_el = 2'd1;
    // {fgt,l1_comms,tge,l2_tde,l2_pdown,l2_rom,l2_dbg,l2_comms,l3_pdown,l3_dbg,l3_comms}
    logic [10:0] cfg_v = '0;
    logic [31:0] rdata, rdata1;
    logic [1:0]  resp, resp1;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    logic [31:0] got_d;
    logic [1:0]  got_r;

    always #2.5 clk = ~clk;

    dbgtrap_top u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_wide(req_wide),
        .cur_el(cur_el), .l1_comms(cfg_v[9]), .l2_pdown(cfg_v[6]),
        .l2_rom(cfg_v[5]), .l2_dbg(cfg_v[4]), .l2_tde(cfg_v[7]),
        .l2_comms(cfg_v[3]), .hyp_tge(cfg_v[8]), .l3_pdown(cfg_v[2]),
        .l3_dbg(cfg_v[1]), .l3_comms(cfg_v[0]), .fgt_present(cfg_v[10]),
        .rdata(rdata), .resp(resp)
    );

    dbgtrap_top #(.DLOCK_EN(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_wide(req_wide),
        .cur_el(cur_el), .l1_comms(cfg_v[9]), .l2_pdown(cfg_v[6]),
        .l2_rom(cfg_v[5]), .l2_dbg(cfg_v[4]), .l2_tde(cfg_v[7]),
        .l2_comms(cfg_v[3]), .hyp_tge(cfg_v[8]), .l3_pdown(cfg_v[2]),
        .l3_dbg(cfg_v[1]), .l3_comms(cfg_v[0]), .fgt_present(cfg_v[10]),
        .rdata(rdata1), .resp(resp1)
    );

    // {el, addr, cfg, expected resp}
    localparam int NV = 18;
    localparam logic [17:0] VEC [NV] = '{
        {2'd0, 3'd6, 11'b01000010010, 2'd1}, // R1 L1 beats L2/L3
        {2'd1, 3'd6, 11'b01000000000, 2'd0}, // R1 only at level 0
        {2'd1, 3'd6, 11'b00000001000, 2'd0}, // R4 comms bit without fgt
        {2'd1, 3'd6, 11'b10000001000, 2'd2}, // R4 comms bit with fgt
        {2'd2, 3'd6, 11'b10000001001, 2'd3}, // R4 level-3 comms with fgt
        {2'd2, 3'd6, 11'b00000000001, 2'd0}, // R4 level-3 comms without fgt
        {2'd1, 3'd1, 11'b00001000000, 2'd2}, // R2 power-down own bit
        {2'd1, 3'd1, 11'b00000010000, 2'd0}, // R2 other class bit
        {2'd2, 3'd1, 11'b00001000100, 2'd3}, // R3 level 2 falls to L3
        {2'd1, 3'd1, 11'b00000000010, 2'd0}, // R3 power-down ignores l3_dbg
        {2'd0, 3'd5, 11'b00010000000, 2'd2}, // R2 tde on ROM
        {2'd1, 3'd5, 11'b00100000010, 2'd2}, // R3 L2 before L3
        {2'd2, 3'd5, 11'b00000000010, 2'd3}, // R3 ROM uses l3_dbg
        {2'd3, 3'd3, 11'b11111111111, 2'd0}, // R3 level 3 never traps
        {2'd1, 3'd3, 11'b00000100000, 2'd0}, // R2 ROM bit on general
        {2'd1, 3'd3, 11'b00000010000, 2'd2}, // R2 general own bit
        {2'd0, 3'd7, 11'b00100000000, 2'd2}, // R2 tge on general
        {2'd2, 3'd3, 11'b00100000000, 2'd0}  // R2 level 2 no L2 trap
    };

    task automatic acc(input logic wr, input logic [2:0] a, input logic [31:0] d,
                       input logic wide);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_wide = wide;
        #1;
        got_d = rdata; got_r = resp;
        @(posedge clk);
        #1;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R9 reset status, R10 tags reset, R11 double lock reset
        acc(1'b0, 3'd1, 0, 1'b0); chk("R9 reset status", got_d, 32'd10);
        acc(1'b0, 3'd4, 0, 1'b0); chk("R10 reset tags", got_d, 32'd0);
        acc(1'b0, 3'd2, 0, 1'b0); chk("R11 reset dlock", got_d, 32'd0);
        acc(1'b0, 3'd5, 0, 1'b0); chk("R6 ROM reads zero", got_d, 32'd0);

        // classification table (reads only)
        for (int i = 0; i < NV; i++) begin
            cur_el = VEC[i][17:16];
            cfg_v  = VEC[i][12:2];
            acc(1'b0, VEC[i][15:13], 0, 1'b0);
            chk($sformatf("R1-table row %0d", i), {30'd0, got_r}, {30'd0, VEC[i][1:0]});
        end
        cur_el = 2'd1; cfg_v = '0;

        // R7 32-bit form key
        acc(1'b1, 3'd0, 32'hC5ACCE54, 1'b0);
        acc(1'b0, 3'd1, 0, 1'b0); chk("R7 wrong key releases", got_d, 32'd8);
        acc(1'b1, 3'd0, 32'hC5ACCE55, 1'b0);
        acc(1'b0, 3'd1, 0, 1'b0); chk("R7 key locks", got_d, 32'd10);
        acc(1'b1, 3'd0, 32'h0000_0001, 1'b0);
        acc(1'b0, 3'd1, 0, 1'b0); chk("R7 bit0 alone in 32-bit form", got_d, 32'd8);
        // R8 64-bit form bit 0
        acc(1'b1, 3'd0, 32'h0000_0003, 1'b1);
        acc(1'b0, 3'd1, 0, 1'b0); chk("R8 wide bit0 locks", got_d, 32'd10);
        acc(1'b1, 3'd0, 32'hC5ACCE54, 1'b1);
        acc(1'b0, 3'd1, 0, 1'b0); chk("R8 wide bit0 clear releases", got_d, 32'd8);

        // R10 claim tags
        acc(1'b1, 3'd3, 32'h0000_01A5, 1'b0);
        acc(1'b0, 3'd3, 0, 1'b0); chk("R10 set view reads ff", got_d, 32'hFF);
        acc(1'b0, 3'd4, 0, 1'b0); chk("R10 tags after set", got_d, 32'hA5);
        acc(1'b1, 3'd4, 32'h0000_0F05, 1'b0);
        acc(1'b0, 3'd4, 0, 1'b0); chk("R10 tags after clear", got_d, 32'hA0);

        // R11 double lock both variants
        acc(1'b1, 3'd2, 32'h3, 1'b0);
        acc(1'b0, 3'd2, 0, 1'b0);
        chk("R11 dlock stored", got_d, 32'd1);
        #0; chk("R11 dlock absent reads zero", rdata1, 32'd0);
        @(negedge clk);
        req_valid = 1'b1; req_addr = 3'd2; #1;
        chk("R11 dlock absent after write", rdata1, 32'd0);
        @(posedge clk); #1 req_valid = 1'b0;

        // R5 trapped writes and reads
        cfg_v = 11'b00000010000; // l2_dbg
        acc(1'b1, 3'd3, 32'hFF, 1'b0); chk("R5 trapped write resp", {30'd0, got_r}, 32'd2);
        acc(1'b0, 3'd4, 0, 1'b0);
        chk("R5 trapped read data", got_d, 32'd0);
        chk("R5 trapped read resp", {30'd0, got_r}, 32'd2);
        cfg_v = 11'b00000000100; // l3_pdown
        acc(1'b1, 3'd0, 32'h1, 1'b1); chk("R5 trapped lock write resp", {30'd0, got_r}, 32'd3);
        cfg_v = '0;
        acc(1'b0, 3'd4, 0, 1'b0); chk("R5 tags unchanged", got_d, 32'hA0);
        acc(1'b0, 3'd1, 0, 1'b0); chk("R5 lock unchanged", got_d, 32'd8);

        // R1 comms trap at level 0 also blocks data
        cur_el = 2'd0; cfg_v = 11'b01000000000;
        acc(1'b0, 3'd6, 0, 1'b0); chk("R1 comms level-0 trap", {30'd0, got_r}, 32'd1);
        cfg_v = '0; cur_el = 2'd1;

        repeat (2) @(posedge clk);
        finish_up();
    end

endmodule